// File: doc/BRIEF.md
# Parallel EEPROM Host Bus Sequencer

This block sits on the host side of an asynchronous byte-wide EEPROM. It turns requests on a simple valid/ready interface into strobe sequences on the memory bus. The memory bus has an address, a data path split into output, output-enable and input, an active-low chip select, an active-low output enable and an active-low write enable. A request names a direction, a start address and, for writes, a byte count. The write bytes arrive on a separate valid/ready stream. Each read fetches one byte. Each write programs one page of up to `PAGE` bytes and then polls the device until the write completes.

All bus timing is expressed in nanoseconds through parameters. Each value is rounded up to whole cycles of `CLK_NS`. The strobe sequence respects the following:
- address setup and hold around the write strobe;
- output-enable setup and hold around the write strobe;
- minimum write pulse width and minimum data setup to the strobe's rising edge;
- read access time;
- bus release time after output-enable or chip-select rises.

Within a page, each write-enable falling edge lands inside the device's retriggerable page window. If the byte stream stalls too long, the page is closed early rather than letting the window lapse.

After the last byte, the sequencer reads the last written location. It repeats that read until bit 7 matches the written data, or until a poll limit derived from the maximum write-cycle time runs out. When the limit runs out, a timeout flag is raised.

Top module: `eeprom_seq`

## Requirements
- R1: While reset is low and after its release: `req_ready`=1, `wr_ready`=0, `mem_cs_n`=`mem_oe_n`=`mem_we_n`=1, `mem_dq_oe`=0, `done`=0, `timeout`=0.
- R2: A read request (`req_write`=0) returns the byte stored at `req_addr` on `rd_data`, valid in the single cycle `done` is 1.
- R3: During a read or poll, chip select and output enable stay low for at least ceil(`T_ACC_NS`/`CLK_NS`) cycles before the data is captured.
- R4: A write request consumes one stream byte per page location. It stores the bytes at successive addresses from `req_addr`.
- R5: Successive page addresses increment only the low log2(`PAGE`) bits, wrapping within the page. The upper address bits stay at those of `req_addr`.
- R6: After the last byte of a page, the sequencer reads the last written address repeatedly. `done` rises only once a read returns bit 7 equal to bit 7 of the last written byte, with `timeout`=0.
- R7: While write enable is low, chip select is low, output enable is high and the data is driven. The low time is at least ceil(max(`T_WP_NS`,`T_DS_NS`)/`CLK_NS`) cycles. Address and data are unchanged in the cycle after write enable rises.
- R8: Within one page, consecutive write-enable falls are less than ceil(`PAGE_WIN_NS`/`CLK_NS`) cycles apart. If the next byte is not offered in time, the page closes and is polled. Stream bytes offered afterwards are not accepted (`wr_ready`=0).
- R9: If polling never succeeds, `done` pulses with `timeout`=1 after the poll limit. `timeout` stays 1 until the next request is accepted, then returns to 0.
- R10: `mem_dq_oe` rises no earlier than ceil(`T_DF_NS`/`CLK_NS`) cycles after output enable was last high-going.
- R11: A write count of 0 is treated as 1, and a count above `PAGE` is limited to `PAGE` bytes.
- R12: `req_ready` is 1 only when idle and drops the cycle after a request is accepted. `done` is high for exactly one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, period `CLK_NS` |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when both high |
| req_write | input | 1 | 1 = page write, 0 = single read |
| req_addr | input | AW | Start address |
| req_len | input | 8 | Write byte count (0 means 1, limited to `PAGE`) |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Write byte accepted when both high |
| wr_data | input | DW | Write byte |
| rd_data | output | DW | Read byte, valid with `done` |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | Polling gave up; held until next request |
| mem_addr | output | AW | Memory address |
| mem_dq_o | output | DW | Data driven to memory |
| mem_dq_oe | output | 1 | Host drives data bus when 1 |
| mem_dq_i | input | DW | Data from memory |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |

## Verification
A wrong internal state shows up at the ports in one of three ways.

A stuck or mis-sequenced state makes a strobe too short or the bus turnaround too early. That shows on the same cycle as the offending edge: a write pulse shorter than its cycle count, or data driven while the device may still be driving. A wrong page counter leaves bytes at wrapped-out addresses, or consumes too many or too few stream bytes. That becomes visible as soon as the page is read back. A broken poll comparison either ends the write while the device is still busy or never ends it. The first shows as `done` while the device model is still busy. The second shows as a `timeout` about a thousand cycles later with the bench's shortened write-cycle time.

// File: rtl/eeprom_seq.sv
module eeprom_seq #(
  parameter int AW          = 17,
  parameter int DW          = 8,
  parameter int PAGE        = 128,
  parameter int CLK_NS      = 20,
  parameter int T_AS_NS     = 10,
  parameter int T_AH_NS     = 100,
  parameter int T_WP_NS     = 150,
  parameter int T_WPH_NS    = 50,
  parameter int T_DS_NS     = 100,
  parameter int T_DH_NS     = 10,
  parameter int T_OES_NS    = 10,
  parameter int T_OEH_NS    = 10,
  parameter int T_ACC_NS    = 150,
  parameter int T_DF_NS     = 70,
  parameter int PAGE_WIN_NS = 150000,
  parameter int WC_NS       = 10000000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [7:0]    req_len,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          done,
  output logic          timeout,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_i,
  output logic          mem_cs_n,
  output logic          mem_oe_n,
  output logic          mem_we_n
);
  function automatic int cyc(int ns);
    return (ns + CLK_NS - 1) / CLK_NS;
  endfunction
  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int AS_C     = mx(mx(cyc(T_AS_NS), cyc(T_OES_NS)), 1);
  localparam int WP_C     = mx(mx(cyc(T_WP_NS), cyc(T_DS_NS)), 1);
  localparam int HOLD_C   = mx(mx(cyc(T_AH_NS), cyc(T_DH_NS)), mx(mx(cyc(T_WPH_NS), cyc(T_OEH_NS)), 1));
  localparam int ACC_C    = mx(cyc(T_ACC_NS), 1);
  localparam int DF_C     = mx(cyc(T_DF_NS), 1);
  localparam int WIN_C    = cyc(PAGE_WIN_NS);
  localparam int CLOSE_C  = WIN_C - AS_C - 2;
  localparam int POLL_MAX = cyc(WC_NS) / (ACC_C + DF_C) + 2;
  localparam int CW       = $clog2(WIN_C + ACC_C + WP_C + HOLD_C + DF_C + 4);
  localparam int PW       = $clog2(POLL_MAX + 1);
  localparam int LW       = $clog2(PAGE + 1);
  localparam int PB       = $clog2(PAGE);

  typedef enum logic [3:0] {
    S_IDLE, S_RD, S_TURN, S_WNXT, S_WSET, S_WPUL, S_WHLD, S_POLL, S_PGAP
  } state_t;

  state_t          st;
  logic [CW-1:0]   cnt, gap;
  logic [PW-1:0]   npoll;
  logic [LW-1:0]   left, eff_len;
  logic [AW-1:0]   addr;
  logic [DW-1:0]   data;
  logic            first;

  assign req_ready = (st == S_IDLE);
  assign wr_ready  = (st == S_WNXT);
  assign mem_addr  = addr;
  assign mem_dq_o  = data;
  assign mem_dq_oe = (st == S_WSET) || (st == S_WPUL) || (st == S_WHLD);
  assign mem_we_n  = (st != S_WPUL);
  assign mem_oe_n  = !((st == S_RD) || (st == S_POLL));
  assign mem_cs_n  = !(mem_dq_oe || !mem_oe_n);

  assign eff_len = (req_len == 8'd0) ? LW'(1) :
                   (req_len > 8'(PAGE)) ? LW'(PAGE) : LW'(req_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; gap <= '0; npoll <= '0; left <= '0;
      addr <= '0; data <= '0; first <= 1'b0; rd_data <= '0;
      done <= 1'b0; timeout <= 1'b0;
    end else begin
      done <= 1'b0;
      cnt  <= cnt + 1'b1;
      if (gap != '1) gap <= gap + 1'b1;
      case (st)
        S_IDLE: if (req_valid) begin
          timeout <= 1'b0;
          addr    <= req_addr;
          cnt     <= '0;
          left    <= eff_len;
          first   <= 1'b1;
          st      <= req_write ? S_WNXT : S_RD;
        end
        S_RD: if (cnt == CW'(ACC_C - 1)) begin
          rd_data <= mem_dq_i; done <= 1'b1; cnt <= '0; st <= S_TURN;
        end
        S_TURN: if (cnt == CW'(DF_C - 1)) st <= S_IDLE;
        S_WNXT: begin
          cnt <= '0;
          if (wr_valid) begin
            data  <= wr_data;
            first <= 1'b0;
            if (!first) addr <= {addr[AW-1:PB], addr[PB-1:0] + 1'b1};
            st    <= S_WSET;
          end else if (!first && gap >= CW'(CLOSE_C)) begin
            npoll <= '0; st <= S_POLL;
          end
        end
        S_WSET: if (cnt == CW'(AS_C - 1)) begin
          cnt <= '0; gap <= '0; st <= S_WPUL;
        end
        S_WPUL: if (cnt == CW'(WP_C - 1)) begin
          cnt <= '0; st <= S_WHLD;
        end
        S_WHLD: if (cnt == CW'(HOLD_C - 1)) begin
          cnt   <= '0;
          left  <= left - 1'b1;
          npoll <= '0;
          st    <= (left == LW'(1)) ? S_POLL : S_WNXT;
        end
        S_POLL: if (cnt == CW'(ACC_C - 1)) begin
          cnt <= '0;
          if (mem_dq_i[DW-1] == data[DW-1]) begin
            done <= 1'b1; st <= S_TURN;
          end else if (npoll == PW'(POLL_MAX - 1)) begin
            done <= 1'b1; timeout <= 1'b1; st <= S_TURN;
          end else begin
            npoll <= npoll + 1'b1; st <= S_PGAP;
          end
        end
        S_PGAP: if (cnt == CW'(DF_C - 1)) begin
          cnt <= '0; st <= S_POLL;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eeprom_seq_chk.sv
module eeprom_seq_chk #(
  parameter int AW    = 17,
  parameter int DW    = 8,
  parameter int WP_C  = 8,
  parameter int ACC_C = 8,
  parameter int DF_C  = 4,
  parameter int WIN_C = 7500
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          done,
  input logic          timeout,
  input logic          mem_cs_n,
  input logic          mem_oe_n,
  input logic          mem_we_n,
  input logic          mem_dq_oe,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_dq_o
);
  logic [31:0] lo_len, oe_lo, oe_hi, since_fall;
  logic        in_pg, pwe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_len <= '0; oe_lo <= '0; oe_hi <= 32'(DF_C);
      since_fall <= '0; in_pg <= 1'b0; pwe <= 1'b1;
    end else begin
      pwe    <= mem_we_n;
      lo_len <= mem_we_n ? '0 : lo_len + 1;
      oe_lo  <= mem_oe_n ? '0 : oe_lo + 1;
      if (mem_oe_n) begin
        if (oe_hi != '1) oe_hi <= oe_hi + 1;
      end else oe_hi <= '0;
      if (pwe && !mem_we_n) begin
        since_fall <= '0; in_pg <= 1'b1;
      end else if (since_fall != '1) since_fall <= since_fall + 1;
      if (!mem_oe_n) in_pg <= 1'b0;
    end
  end

  // R7
  we_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_cs_n && mem_oe_n && mem_dq_oe));
  // R7
  we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> lo_len >= 32'(WP_C));
  // R7
  we_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |=> ($stable(mem_addr) && $stable(mem_dq_o) && mem_dq_oe));
  // R8
  page_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwe && !mem_we_n && in_pg) |-> since_fall < 32'(WIN_C));
  // R3
  rd_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> oe_lo >= 32'(ACC_C));
  // R10
  bus_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> oe_hi >= 32'(DF_C));
  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R12
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  // R9
  timeout_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |-> done);
endmodule

bind eeprom_seq eeprom_seq_chk #(
  .AW(AW), .DW(DW), .WP_C(WP_C), .ACC_C(ACC_C), .DF_C(DF_C), .WIN_C(WIN_C)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .done(done), .timeout(timeout), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
  .mem_we_n(mem_we_n), .mem_dq_oe(mem_dq_oe), .mem_addr(mem_addr), .mem_dq_o(mem_dq_o)
);

// File: tb/sim_eeprom_seq.sv
module sim_eeprom_seq;
  localparam int E_WP  = 8;    // ceil(150/20)
  localparam int E_ACC = 8;    // ceil(150/20)
  localparam int E_DF  = 4;    // ceil(70/20)
  localparam int E_WIN = 200;  // ceil(4000/20)
  localparam int BUSY  = 100;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0, req_valid = 1'b0, req_write = 1'b0, wr_valid = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_len = '0, wr_data = '0;
  logic        req_ready, wr_ready, done, timeout;
  logic [7:0]  rd_data, mem_dq_o, mem_dq_i;
  logic [16:0] mem_addr;
  logic        mem_dq_oe, mem_cs_n, mem_oe_n, mem_we_n;

  eeprom_seq #(.PAGE_WIN_NS(4000), .WC_NS(20000)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_len(req_len),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_data(rd_data), .done(done), .timeout(timeout),
    .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
    .mem_dq_i(mem_dq_i), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n));

  // device model
  logic [7:0] mem [0:255];
  logic [7:0] last_wr = 8'h00;
  int         busy = 0;
  bit         stuck = 1'b0;
  logic       pwe = 1'b1;
  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h5A;
      busy <= 0;
    end else begin
      pwe <= mem_we_n;
      if (!pwe && mem_we_n && !mem_cs_n) begin
        mem[mem_addr[7:0]] <= mem_dq_o; last_wr <= mem_dq_o; busy <= BUSY;
      end else if (busy > 0 && !stuck) busy <= busy - 1;
    end
  end
  assign mem_dq_i = (!mem_cs_n && !mem_oe_n) ?
                    ((busy != 0) ? {~last_wr[7], last_wr[6:0]} : mem[mem_addr[7:0]]) : 8'h00;

  // bus monitor
  int we_low = 0, min_we_low = 999, oe_low = 0, min_oe_low = 999;
  int oe_hi = 100, min_turn = 999, since_fall = 0, max_gap = 0, oe_falls = 0;
  bit in_pg = 0, mpwe = 1, mpoe = 1, pdq = 0;
  always @(negedge clk) begin
    if (!mem_we_n) we_low++;
    else begin if (we_low > 0 && we_low < min_we_low) min_we_low = we_low; we_low = 0; end
    if (!mem_oe_n) oe_low++;
    else begin if (oe_low > 0 && oe_low < min_oe_low) min_oe_low = oe_low; oe_low = 0; end
    if (mem_dq_oe && !pdq && oe_hi < min_turn) min_turn = oe_hi;
    oe_hi = mem_oe_n ? oe_hi + 1 : 0;
    pdq = mem_dq_oe;
    if (mpwe && !mem_we_n) begin
      if (in_pg && since_fall > max_gap) max_gap = since_fall;
      in_pg = 1; since_fall = 0;
    end else since_fall++;
    if (mpoe && !mem_oe_n) oe_falls++;
    if (!mem_oe_n) in_pg = 0;
    mpwe = mem_we_n; mpoe = mem_oe_n;
  end

  int checks = 0, fails = 0, cycles = 0;
  logic [7:0] got;
  bit         got_to;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic send_req(bit wr, logic [16:0] a, logic [7:0] n);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_len = n;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic send_byte(logic [7:0] d, int pre_gap);
    repeat (pre_gap) @(negedge clk);
    wr_valid = 1'b1; wr_data = d;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
    got = rd_data; got_to = timeout;
    @(negedge clk);
    check(!done, "R12 done width", done, 0);
  endtask

  task automatic do_read(logic [16:0] a);
    send_req(1'b0, a, 8'd0);
    wait_done();
  endtask

  localparam logic [24:0] VEC [6] = '{
    {17'h00003, 8'h59}, {17'h0001F, 8'h45}, {17'h10040, 8'h1A},
    {17'h0007E, 8'h24}, {17'h00081, 8'hDB}, {17'h1FFFF, 8'hA5}};
  localparam logic [7:0] PG [4] = '{8'h3C, 8'hA5, 8'h0F, 8'hF0};

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(req_ready && !wr_ready && mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe && !done && !timeout,
          "R1 reset", {req_ready, wr_ready, mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe, done, timeout}, 8'b10111000);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && mem_cs_n && mem_we_n && !mem_dq_oe, "R1 after release",
          {req_ready, mem_cs_n, mem_we_n, mem_dq_oe}, 4'b1110);

    // R2 table of reads
    for (int v = 0; v < 6; v++) begin
      do_read(VEC[v][24:8]);
      check(got == VEC[v][7:0], "R2 read data", got, VEC[v][7:0]);
    end
    // R3 access time
    check(min_oe_low >= E_ACC, "R3 access cycles", min_oe_low, E_ACC);

    // R4, R6 page of 4 with gaps
    oe_falls = 0;
    send_req(1'b1, 17'h00010, 8'd4);
    for (int i = 0; i < 4; i++) send_byte(PG[i], 30);
    wait_done();
    check(busy == 0 && !got_to, "R6 done only after ready", busy, 0);
    check(oe_falls >= 2, "R6 repeated polling", oe_falls, 2);
    for (int i = 0; i < 4; i++) begin
      do_read(17'h00010 + 17'(i));
      check(got == PG[i], "R4 page readback", got, PG[i]);
    end

    // R5 wrap within page; R10 after read then write
    send_req(1'b1, 17'h000FE, 8'd3);
    send_byte(8'h81, 0); send_byte(8'h82, 0); send_byte(8'h83, 0);
    wait_done();
    check(mem[8'hFF] == 8'h82 && mem[8'h80] == 8'h83, "R5 wrap address", mem[8'h80], 8'h83);
    check(mem[8'h00] == 8'h5A, "R5 no carry out", mem[8'h00], 8'h5A);
    check(min_turn >= E_DF, "R10 bus turnaround", min_turn, E_DF);

    // R8 stall closes page early
    send_req(1'b1, 17'h00020, 8'd3);
    send_byte(8'hA1, 0);
    wait_done();
    check(mem[8'h20] == 8'hA1, "R8 first byte kept", mem[8'h20], 8'hA1);
    check(mem[8'h21] == 8'h7B, "R8 remaining untouched", mem[8'h21], 8'h7B);
    wr_valid = 1'b1; wr_data = 8'hEE;
    begin
      bit seen = 0;
      repeat (10) begin @(negedge clk); if (wr_ready) seen = 1; end
      check(!seen, "R8 late byte refused", seen, 0);
    end
    wr_valid = 1'b0;
    check(max_gap < E_WIN, "R8 page window", max_gap, E_WIN);

    // R11 length zero means one
    send_req(1'b1, 17'h00030, 8'd0);
    send_byte(8'h11, 0);
    wr_valid = 1'b1; wr_data = 8'h22;
    wait_done();
    wr_valid = 1'b0;
    check(mem[8'h30] == 8'h11 && mem[8'h31] == 8'h6B, "R11 zero length", mem[8'h31], 8'h6B);

    // R11 length above page clamped
    send_req(1'b1, 17'h00080, 8'd200);
    for (int i = 0; i < 128; i++) send_byte(8'(i) ^ 8'hC3, 0);
    wr_valid = 1'b1; wr_data = 8'h55;
    wait_done();
    wr_valid = 1'b0;
    begin
      int bad = 0;
      for (int i = 0; i < 128; i++) if (mem[8'h80 + 8'(i)] != (8'(i) ^ 8'hC3)) bad++;
      check(bad == 0, "R11 clamp to page", bad, 0);
    end
    check(min_we_low >= E_WP, "R7 write pulse", min_we_low, E_WP);

    // R9 timeout
    stuck = 1'b1;
    send_req(1'b1, 17'h00040, 8'd1);
    send_byte(8'h99, 0);
    wait_done();
    check(got_to, "R9 timeout raised", got_to, 1);
    repeat (5) @(negedge clk);
    check(timeout, "R9 timeout held", timeout, 1);
    stuck = 1'b0;
    repeat (BUSY + 5) @(negedge clk);
    do_read(17'h00003);
    check(!got_to && got == 8'h59, "R9 cleared by next request", got_to, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule